// File: doc/BRIEF.md
# Six-Slot TDM Serial Output Framer

This block places the samples of six channels on one serial data line. Each sampling instant produces one frame. The frame has six fixed slots, one slot for each channel. On a sample strobe the block captures all six channel words, the power-up mask and the operating mode together. It then walks through the frame, moving forward one bit period each time the serial-clock enable is high. Each slot opens with a one-period frame-sync marker. Sixteen data bits follow, most significant bit first.

A channel that is powered down keeps its slot position. During that slot the block drives no frame-sync, and the data-output-enable stays low so that an external tri-state pad releases the line. After reset the block is in program mode. In program mode the first slot carries zeros and the rest of the frame is released. Converter data appears only once data mode or mixed mode has been latched by a sample strobe.

Top module: `tdm_framer`

## Requirements
- R1: While reset is held, and after reset until the first sample strobe, frameSync, dataOe and serData are all low, and pulses on bitEn have no effect.
- R2: A frame has 6 slots of 17 bit periods each. Slot k (k=0 is channel 1) occupies periods 17k to 17k+16, counted from 0 in the cycle after the strobe. The period advances only in a cycle where bitEn is high, and the outputs hold their values between such cycles.
- R3: frameSync is high during period 0 of each live slot and low at all other times. dataOe is low while frameSync is high.
- R4: In data or mixed mode, periods 1 to 16 of a live slot k drive dataOe high. serData carries bits 16k+15 down to 16k of chanWords, most significant bit first.
- R5: A slot whose powerMask bit k is 0 keeps dataOe and frameSync low for all 17 of its periods. The positions of the other slots do not change.
- R6: modeSel 2'b00 (program) and 2'b11 (reserved, treated as program) make only slot 0 live, whatever the mask. That slot sends 16 zero bits.
- R7: modeSel 2'b01 (data) and 2'b10 (mixed) transmit identically and follow the mask.
- R8: chanWords, powerMask and modeSel are latched on sampleStrobe. Changes to them during a frame do not affect that frame.
- R9: A sampleStrobe arriving during a frame restarts at period 0 of a new frame built from freshly captured inputs. The outputs in the cycle after any strobe have dataOe low.
- R10: After the last period of slot 5 is left, all outputs stay low until the next strobe, whatever bitEn does.
- R11: serData is low whenever dataOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | Starts a frame and captures words, mask and mode |
| bitEn | input | 1 | Serial-clock enable; advances one bit period |
| chanWords | input | 96 | Six 16-bit channel words; channel 1 in bits 15:0 |
| powerMask | input | 6 | Per-channel power-up; bit 0 is channel 1 |
| modeSel | input | 2 | 00 program, 01 data, 10 mixed, 11 reserved (program) |
| serData | output | 1 | Serial data bit |
| dataOe | output | 1 | Drive enable for the data pad |
| frameSync | output | 1 | One-period marker before each transmitted word |

## Verification
All 64 power-up masks are swept in data mode, each with different channel words and with one, two or three clock cycles per bit period. This separates slot-position faults from mask decoding faults and from faults that advance the frame without bitEn. Mixed mode is run with alternate-channel masks, and program mode with full, empty and sparse masks, to tell the mode decode apart from the mask. The inputs are scrambled right after every strobe, which exposes any path that misses the latch. A strobe in the middle of a frame and bitEn pulses after the end of a frame cover the restart and idle behaviour.

// File: rtl/tdm_framer_pkg.sv
package tdm_framer_pkg;

  typedef enum logic [1:0] {
    MODE_PROG = 2'b00,
    MODE_DATA = 2'b01,
    MODE_MIXED = 2'b10,
    MODE_RSVD = 2'b11
  } modeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the channel bank
    logic load;      // load shifter for the coming slot
    logic zeroLoad;  // load zeros instead of a channel word
    logic shift;     // move to next bit
  } dpCtlT;

  function automatic logic isProgLike(modeT m);
    return (m == MODE_PROG) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/tdm_framer_ctrl.sv
module tdm_framer_ctrl
  import tdm_framer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int POS_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStrobe,
  input  logic              bitEn,
  input  logic [NUM_CH-1:0] powerMask,
  input  logic [1:0]        modeSel,
  output dpCtlT             dpCtl,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              dataOe,
  output logic              frameSync
);

  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(WORD_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

  logic              active;
  logic [POS_W-1:0]  bitPos;
  logic [NUM_CH-1:0] maskLat;
  modeT              modeLat;
  logic              progLike;
  logic              slotLive;
  logic              stepNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitPos  <= '0;
      maskLat <= '0;
      modeLat <= MODE_PROG;
    end else if (sampleStrobe) begin
      active  <= 1'b1;
      slotIdx <= '0;
      bitPos  <= '0;
      maskLat <= powerMask;
      modeLat <= modeT'(modeSel);
    end else if (stepNow) begin
      if (bitPos == LAST_POS) begin
        bitPos <= '0;
        if (slotIdx == LAST_SLOT) begin
          active  <= 1'b0;
          slotIdx <= '0;
        end else begin
          slotIdx <= slotIdx + 1'b1;
        end
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  always_comb begin
    stepNow  = active && bitEn && !sampleStrobe;
    progLike = isProgLike(modeLat);
    slotLive = progLike ? (slotIdx == '0) : maskLat[slotIdx];

    frameSync = active && slotLive && (bitPos == '0);
    dataOe    = active && slotLive && (bitPos != '0);

    dpCtl.capture  = sampleStrobe;
    dpCtl.load     = stepNow && (bitPos == '0);
    dpCtl.zeroLoad = progLike;
    dpCtl.shift    = stepNow && (bitPos != '0) && (bitPos != LAST_POS);
  end

endmodule

// File: rtl/tdm_framer_dp.sv
module tdm_framer_dp
  import tdm_framer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtlT                    dpCtl,
  input  logic [SLOT_W-1:0]        slotIdx,
  input  logic [NUM_CH*WORD_W-1:0] chanWords,
  output logic                     msbOut
);

  logic [WORD_W-1:0] bank [NUM_CH];
  logic [WORD_W-1:0] shifter;

  // One capture register per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[ch] <= '0;
      else if (dpCtl.capture)
        bank[ch] <= chanWords[ch*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      shifter <= '0;
    else if (dpCtl.load)
      shifter <= dpCtl.zeroLoad ? '0 : bank[slotIdx];
    else if (dpCtl.shift)
      shifter <= {shifter[WORD_W-2:0], 1'b0};
  end

  assign msbOut = shifter[WORD_W-1];

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_framer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStrobe,
  input  logic                     bitEn,
  input  logic [NUM_CH*WORD_W-1:0] chanWords,
  input  logic [NUM_CH-1:0]        powerMask,
  input  logic [1:0]               modeSel,
  output logic                     serData,
  output logic                     dataOe,
  output logic                     frameSync
);

  dpCtlT             dpCtl;
  logic [SLOT_W-1:0] slotIdx;
  logic              msbOut;

  tdm_framer_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .bitEn(bitEn),
    .powerMask(powerMask), .modeSel(modeSel), .dpCtl(dpCtl),
    .slotIdx(slotIdx), .dataOe(dataOe), .frameSync(frameSync)
  );

  tdm_framer_dp #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .slotIdx(slotIdx),
    .chanWords(chanWords), .msbOut(msbOut)
  );

  assign serData = dataOe & msbOut;

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk (
  input logic clk,
  input logic rstN,
  input logic sampleStrobe,
  input logic bitEn,
  input logic serData,
  input logic dataOe,
  input logic frameSync
);

  AST_SYNC_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> !dataOe); // R3

  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> !serData); // R11

  AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !sampleStrobe) |=> $stable({serData, dataOe, frameSync})); // R2

  AST_SYNC_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && bitEn && !sampleStrobe) |=> !frameSync); // R3

  AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !dataOe); // R9

endmodule

bind tdm_framer tdm_framer_chk u_chk (.*);

// File: tb/tdm_framer_tb.sv
module tdm_framer_tb;
  localparam int NCH = 6;
  localparam int WW = 16;
  localparam int SLOTP = WW + 1;
  localparam int FRAMEP = NCH * SLOTP;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, sampleStrobe, bitEn;
  logic [NCH*WW-1:0] chanWords;
  logic [NCH-1:0] powerMask;
  logic [1:0] modeSel;
  logic serData, dataOe, frameSync;

  int errors = 0;
  int checks = 0;
  logic [WW-1:0] expWords [NCH];
  logic [NCH-1:0] expMask;
  logic expProg;

  tdm_framer u_dut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .bitEn(bitEn),
    .chanWords(chanWords), .powerMask(powerMask), .modeSel(modeSel),
    .serData(serData), .dataOe(dataOe), .frameSync(frameSync)
  );

  task automatic chk(logic got, logic exp, string req, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic checkIdle(string req);
    chk(frameSync, 1'b0, req, "idle sync");
    chk(dataOe, 1'b0, req, "idle oe");
    chk(serData, 1'b0, req, "idle data");
  endtask

  task automatic checkPeriod(int p, string tag);
    int k = p / SLOTP;
    int q = p % SLOTP;
    logic live, fsE, oeE, sdE;
    live = expProg ? (k == 0) : expMask[k];
    fsE = live && (q == 0);
    oeE = live && (q != 0);
    sdE = 1'b0;
    if (oeE && !expProg) sdE = expWords[k][WW - q];
    chk(frameSync, fsE, {tag, " R3"}, $sformatf("sync p%0d", p));
    chk(dataOe, oeE, live ? {tag, " R2"} : {tag, " R5"}, $sformatf("oe p%0d", p));
    chk(serData, sdE, oeE ? (expProg ? {tag, " R6"} : {tag, " R4"}) : {tag, " R11"},
        $sformatf("data p%0d", p));
  endtask

  task automatic startFrame(logic [1:0] mode, logic [NCH-1:0] mask, int seed);
    for (int k = 0; k < NCH; k++) begin
      expWords[k] = WW'(seed * 40503 + k * 7919 + 16'h1357) ^ WW'(k << (seed % 11));
      chanWords[k*WW +: WW] = expWords[k];
    end
    powerMask = mask;
    modeSel = mode;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    expMask = mask;
    expProg = (mode == 2'b00) || (mode == 2'b11);
    // R8: disturb every latched input right after capture
    chanWords = ~chanWords;
    powerMask = ~mask;
    modeSel = expProg ? 2'b01 : 2'b00;
  endtask

  task automatic runPeriods(int from, int upto, int gap, string tag);
    for (int p = from; p < upto; p++) begin
      checkPeriod(p, tag);
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      for (int g = 0; g < gap; g++) begin
        if (p + 1 < FRAMEP) checkPeriod(p + 1, "R2");
        @(negedge clk);
      end
    end
  endtask

  task automatic endOfFrame();
    checkIdle("R10");
    for (int i = 0; i < 3; i++) begin
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      checkIdle("R10");
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    sampleStrobe = 1'b0;
    bitEn = 1'b0;
    chanWords = '1;
    powerMask = '1;
    modeSel = 2'b01;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    for (int i = 0; i < 4; i++) begin
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      checkIdle("R1");
    end

    // Data mode: every mask, varying bit period length
    for (int m = 0; m < 64; m++) begin
      startFrame(2'b01, NCH'(m), m + 1);
      runPeriods(0, FRAMEP, m % 3, "R8");
      endOfFrame();
    end

    // Mixed mode behaves as data mode (R7)
    startFrame(2'b10, 6'h15, 201);
    runPeriods(0, FRAMEP, 0, "R7");
    endOfFrame();
    startFrame(2'b10, 6'h2A, 202);
    runPeriods(0, FRAMEP, 1, "R7");
    endOfFrame();
    startFrame(2'b10, 6'h3F, 203);
    runPeriods(0, FRAMEP, 0, "R7");
    endOfFrame();

    // Program mode and reserved code (R6)
    startFrame(2'b00, 6'h3F, 301);
    runPeriods(0, FRAMEP, 0, "R6");
    endOfFrame();
    startFrame(2'b00, 6'h00, 302);
    runPeriods(0, FRAMEP, 1, "R6");
    endOfFrame();
    startFrame(2'b00, 6'h2A, 303);
    runPeriods(0, FRAMEP, 0, "R6");
    endOfFrame();
    startFrame(2'b11, 6'h3F, 304);
    runPeriods(0, FRAMEP, 0, "R6");
    endOfFrame();

    // Restart in the middle of a frame (R9)
    startFrame(2'b01, 6'h3F, 401);
    runPeriods(0, 40, 0, "R9");
    startFrame(2'b01, 6'h15, 402);
    runPeriods(0, FRAMEP, 0, "R9");
    endOfFrame();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule